// File: doc/BRIEF.md
# Reset Cause and Soft Reset Control Register

This block keeps a small record of why the system last came out of reset and gives software a way to ask for a new one. A single 32-bit word on a simple register port carries five cause and request flags. The rest of the word is reserved. Some flags are cleared by writing a one, and others take the value written. A write that asks for a reset produces a one-cycle request pulse, which the system reset logic outside the block acts on.

Two reset inputs drive the block. The power-up reset wipes everything, including a saturating counter of system resets. The system reset is counted at every clock edge where it is sampled low. When that happens while the counter is still zero, the register is loaded with only the power-on flag, so the power-on cause is reported for the first reset after power-up only. A software power-on request clears the counter, so the next system reset is again reported as a power-on. A software externally-initiated request leaves the counter alone.

Top module: `reset_cause_ctrl`

## Requirements
- R1: Bits 26:0 of the live word always read as zero, and writing ones to them changes no state and raises no request.
- R2: Bit 31 (power-on), bit 28 (button power-on) and bit 27 (button external) are cleared by writing a one and kept by writing a zero. A write never sets them.
- R3: Bit 30 (soft power-on) and bit 29 (soft external) take the written value on every write to the live word.
- R4: Only the word at `REG_OFFSET + 4` is live, which means address bits 15:3 match `REG_OFFSET` and address bit 2 is set. The word at `REG_OFFSET` and every other address read as zero and ignore writes.
- R5: At a clock edge where the system reset is sampled low while the reset counter is zero, the register is loaded with 0x8000_0000. At later system resets it keeps its value.
- R6: Writing bit 30 as 1 raises the reset request and clears the counter, so the next system reset loads 0x8000_0000 again. This also holds when bit 29 is written as 1 in the same write.
- R7: Writing bit 29 as 1 with bit 30 as 0 raises the reset request and leaves the counter unchanged, so the next system reset keeps the register value.
- R8: The reset request is high for exactly the one cycle after the clock edge that takes the requesting write, and low at all other times.
- R9: The counter saturates at its maximum instead of wrapping, so any number of system resets after the first never reloads the power-on value.
- R10: While the power-up reset is applied, the register reads zero and the request output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-up reset, synchronous, active low; clears the counter and the register |
| sys_rst_n | input | 1 | System reset, synchronous, active low; counted and may load the power-on cause |
| bus_sel | input | 1 | Register port access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address and the stored flags |
| sys_reset_req | output | 1 | One-cycle system reset request pulse |

## Verification
Read data follows the address in the same cycle. The bench drives inputs on the falling edge and samples a short delay later in the same half cycle. A write takes effect at the next rising edge, and the register and the request pulse are both sampled on the falling edge that follows it. The pulse is sampled again one cycle later, where it must be low. The effect of a system reset is checked by reading the word on the first falling edge after the reset is released. This accounts for the counter and the register updating at the same edges where the reset is sampled low.

// File: rtl/rsc_pkg.sv
// Package: shared bit positions and masks of the reset cause word.
// Assumes a 32-bit register word; the flags sit in the top five bits.
package rsc_pkg;
    localparam int WORD_W   = 32;
    localparam int FLAG_LSB = 27;
    localparam int FLAG_W   = WORD_W - FLAG_LSB;

    // Flag positions inside the stored five-bit field (field bit = word bit - FLAG_LSB)
    localparam int F_POR      = 4;   // word bit 31
    localparam int F_SOFT_POR = 3;   // word bit 30
    localparam int F_SOFT_EXT = 2;   // word bit 29
    localparam int F_BTN_POR  = 1;   // word bit 28
    localparam int F_BTN_EXT  = 0;   // word bit 27

    localparam logic [FLAG_W-1:0] W1C_MASK  = 5'b10011;
    localparam logic [FLAG_W-1:0] LOAD_MASK = 5'b01100;
    localparam logic [FLAG_W-1:0] POR_VALUE = 5'b10000;
endpackage

// File: rtl/rsc_addr_decode.sv
// Module: rsc_addr_decode
// Flags an access that targets the live register word: the doubleword at
// REG_OFFSET with address bit 2 set. Assumes REG_OFFSET is 8-byte aligned.
module rsc_addr_decode #(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hF020
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              reg_hit
);
    localparam int HI = ADDR_W - 1;

    // Compare the doubleword index, then pick the upper word of it
    always_comb begin
        reg_hit = bus_sel && (bus_addr[HI:3] == REG_OFFSET[HI:3]) && bus_addr[2];
    end
endmodule

// File: rtl/rsc_boot_counter.sv
// Module: rsc_boot_counter
// Counts clock edges with the system reset sampled low, saturating at its
// maximum. Reports when the count is still zero (first reset since power-up
// or since a software power-on request). Assumes synchronous active-low resets.
module rsc_boot_counter #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic pwr_rst_n,
    input  logic sys_rst_n,
    input  logic clr,
    output logic first_reset
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Saturating reset counter, cleared by power-up or a software power-on request
    always_ff @(posedge clk) begin
        if (!pwr_rst_n) begin
            cnt_q <= '0;
        end else if (!sys_rst_n) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (clr) begin
            cnt_q <= '0;
        end
    end

    // Zero count marks the next system reset as a power-on
    always_comb begin
        first_reset = (cnt_q == '0);
    end

    // R9: a saturated counter stays saturated through further resets
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (!sys_rst_n && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R6: a software power-on request re-arms first-reset detection
    assert_rearm_R6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (sys_rst_n && clr) |=> first_reset);
endmodule

// File: rtl/rsc_cause_reg.sv
// Module: rsc_cause_reg
// Holds the five reset cause/request flags and forms the reset request pulse.
// Assumes wr_en is already qualified by the address decode; writes are ignored
// while the system reset is sampled low.
module rsc_cause_reg
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              pwr_rst_n,
    input  logic              sys_rst_n,
    input  logic              first_reset,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_flags,
    output logic [FLAG_W-1:0] flags_q,
    output logic              soft_por_wr,
    output logic              req_q
);
    logic              wr_ok;
    logic              req_d;
    logic [FLAG_W-1:0] flags_wr;

    // Write qualification and the next flag value for a write
    always_comb begin
        wr_ok       = wr_en && sys_rst_n;
        soft_por_wr = wr_ok && wr_flags[F_SOFT_POR];
        req_d       = wr_ok && (wr_flags[F_SOFT_POR] || wr_flags[F_SOFT_EXT]);
        flags_wr    = (flags_q & ~(wr_flags & W1C_MASK) & ~LOAD_MASK)
                    | (wr_flags & LOAD_MASK);
    end

    // Flag storage: cleared at power-up, loaded on a first reset, else written
    always_ff @(posedge clk) begin
        if (!pwr_rst_n) begin
            flags_q <= '0;
        end else if (!sys_rst_n) begin
            if (first_reset) begin
                flags_q <= POR_VALUE;
            end
        end else if (wr_ok) begin
            flags_q <= flags_wr;
        end
    end

    // Request pulse register, one cycle after the requesting write
    always_ff @(posedge clk) begin
        if (!pwr_rst_n || !sys_rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    // R5: a first reset leaves only the power-on flag set
    assert_por_load_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (!sys_rst_n && first_reset) |=> (flags_q == POR_VALUE));

    // R5: a later reset keeps the flags
    assert_keep_on_reset_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (!sys_rst_n && !first_reset) |=> $stable(flags_q));

    // R2: writing one to the power-on flag clears it
    assert_w1c_por_R2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr_en && sys_rst_n && wr_flags[F_POR]) |=> !flags_q[F_POR]);

    // R3: the soft flags follow the written value
    assert_load_soft_R3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr_en && sys_rst_n) |=> (flags_q[F_SOFT_POR:F_SOFT_EXT]
                                  == $past(wr_flags[F_SOFT_POR:F_SOFT_EXT])));

    // R8: the request only follows a requesting write one cycle earlier
    assert_req_source_R8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        req_q |-> $past(wr_en && sys_rst_n
                        && (wr_flags[F_SOFT_POR] || wr_flags[F_SOFT_EXT])));
endmodule

// File: rtl/reset_cause_ctrl.sv
// Module: reset_cause_ctrl (top)
// Reset cause register with software reset request. Read data is combinational;
// writes and the request pulse are registered. Assumes one access per cycle.
module reset_cause_ctrl
    import rsc_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hF020,
    parameter int                CNT_W      = 3
) (
    input  logic              clk,
    input  logic              pwr_rst_n,
    input  logic              sys_rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sys_reset_req
);
    logic              reg_hit;
    logic              first_reset;
    logic              soft_por_wr;
    logic [FLAG_W-1:0] flags_q;

    rsc_addr_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .reg_hit  (reg_hit)
    );

    rsc_boot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .pwr_rst_n   (pwr_rst_n),
        .sys_rst_n   (sys_rst_n),
        .clr         (soft_por_wr),
        .first_reset (first_reset)
    );

    rsc_cause_reg u_flags (
        .clk         (clk),
        .pwr_rst_n   (pwr_rst_n),
        .sys_rst_n   (sys_rst_n),
        .first_reset (first_reset),
        .wr_en       (reg_hit && bus_we),
        .wr_flags    (bus_wdata[WORD_W-1:FLAG_LSB]),
        .flags_q     (flags_q),
        .soft_por_wr (soft_por_wr),
        .req_q       (sys_reset_req)
    );

    // Read mux: the live word returns the flags, everything else reads zero
    always_comb begin
        bus_rdata = '0;
        if (reg_hit && !bus_we) begin
            bus_rdata = {flags_q, {FLAG_LSB{1'b0}}};
        end
    end

    // R1: reserved bits never read back as one
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        bus_rdata[FLAG_LSB-1:0] == '0);

    // R4: the lower word of the doubleword reads zero
    assert_dead_word_R4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (bus_sel && !bus_addr[2]) |-> (bus_rdata == '0));

    // R10: no request during power-up reset
    always_ff @(posedge clk) begin
        if (!pwr_rst_n) begin
            assert_idle_in_pwr_R10: assert (!sys_reset_req);
        end
    end
endmodule

// File: tb/tb_reset_cause_ctrl.sv
module tb_reset_cause_ctrl;
    localparam logic [15:0] LIVE = 16'hF024;
    localparam logic [15:0] DEAD = 16'hF020;

    logic        clk = 1'b0;
    logic        pwr_rst_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    reset_cause_ctrl dut (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst_n(sys_rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_reset_req(sys_reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Write; p1 is the request one cycle after, p2 the cycle after that
    task automatic wr(input logic [15:0] a, input logic [31:0] d,
                      output logic p1, output logic p2);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        #1 p1 = sys_reset_req;
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        #1 p2 = sys_reset_req;
    endtask

    task automatic sys_reset(input int cycles);
        @(negedge clk);
        sys_rst_n = 1'b0;
        repeat (cycles) @(negedge clk);
        sys_rst_n = 1'b1;
    endtask

    task automatic t_power_up;
        logic [31:0] d;
        rd(LIVE, d);
        check("R10 flags in power-up reset", d, 32'h0);
        check("R10 request in power-up reset", {31'b0, sys_reset_req}, 32'h0);
        @(negedge clk); pwr_rst_n = 1'b1;
        @(negedge clk); sys_rst_n = 1'b1;
        rd(LIVE, d);
        check("R5 first reset loads power-on", d, 32'h8000_0000);
        rd(DEAD, d);
        check("R4 lower word reads zero", d, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d; logic p1, p2;
        wr(LIVE, 32'h0, p1, p2);
        rd(LIVE, d);
        check("R2 write zero keeps bit 31", d, 32'h8000_0000);
        check("R2 no request on zero write", {31'b0, p1}, 32'h0);
        wr(LIVE, 32'h8000_0000, p1, p2);
        rd(LIVE, d);
        check("R2 write one clears bit 31", d, 32'h0);
        wr(LIVE, 32'h1800_0000, p1, p2);
        rd(LIVE, d);
        check("R2 bits 28/27 never set by write", d, 32'h0);
    endtask

    task automatic t_reserved_and_decode;
        logic [31:0] d; logic p1, p2;
        wr(LIVE, 32'h07FF_FFFF, p1, p2);
        rd(LIVE, d);
        check("R1 reserved bits read zero", d, 32'h0);
        check("R1 reserved write no request", {31'b0, p1}, 32'h0);
        wr(DEAD, 32'h6000_0000, p1, p2);
        rd(LIVE, d);
        check("R4 lower word write ignored", d, 32'h0);
        check("R4 lower word write no request", {31'b0, p1}, 32'h0);
        wr(16'hF02C, 32'h6000_0000, p1, p2);
        rd(LIVE, d);
        check("R4 other address write ignored", d, 32'h0);
        check("R4 other address no request", {31'b0, p1}, 32'h0);
    endtask

    task automatic t_soft_ext;
        logic [31:0] d; logic p1, p2;
        wr(LIVE, 32'h2000_0000, p1, p2);
        rd(LIVE, d);
        check("R3 bit 29 loads one", d, 32'h2000_0000);
        check("R7 request pulse after write", {31'b0, p1}, 32'h1);
        check("R8 request lasts one cycle", {31'b0, p2}, 32'h0);
        wr(LIVE, 32'h0, p1, p2);
        rd(LIVE, d);
        check("R3 bit 29 loads zero", d, 32'h0);
        wr(LIVE, 32'h2000_0000, p1, p2);
        sys_reset(1);
        rd(LIVE, d);
        check("R7 counter kept, register kept", d, 32'h2000_0000);
    endtask

    task automatic t_soft_por;
        logic [31:0] d; logic p1, p2;
        wr(LIVE, 32'h4000_0000, p1, p2);
        rd(LIVE, d);
        check("R3 bit 30 loads, bit 29 cleared", d, 32'h4000_0000);
        check("R6 request pulse after write", {31'b0, p1}, 32'h1);
        check("R8 request lasts one cycle", {31'b0, p2}, 32'h0);
        sys_reset(1);
        rd(LIVE, d);
        check("R6 next reset reloads power-on", d, 32'h8000_0000);
    endtask

    task automatic t_saturate;
        logic [31:0] d; logic p1, p2;
        wr(LIVE, 32'h8000_0000, p1, p2);
        sys_reset(12);
        rd(LIVE, d);
        check("R9 no reload after many resets", d, 32'h0);
        check("R8 request low after reset", {31'b0, sys_reset_req}, 32'h0);
        wr(LIVE, 32'h6000_0000, p1, p2);
        check("R6 both bits give one request", {p2, p1}, 32'h1);
        sys_reset(1);
        rd(LIVE, d);
        check("R6 power-on wins over external", d, 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_power_up();
        t_w1c();
        t_reserved_and_decode();
        t_soft_ext();
        t_soft_por();
        t_saturate();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule